// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches two external interrupt pins and turns activity on them into interrupt requests for a processor core. Each pin passes through a synchronizer and is then sampled once per clock. The detector compares each sample with the one taken in the previous cycle, so it can react to a low level, to any change, to a falling edge only or to a rising edge only. The pin is sensed whatever its direction. Software can therefore raise an interrupt by driving a pin configured as an output.

Every pin has a two-bit sense field, an enable bit and a pending flag. An edge or change event sets the flag. The flag is cleared when the core acknowledges the vector, or when software writes a one to it. In low-level mode no flag is kept: the request follows the pin directly. A request goes out only when the pin's enable and the global interrupt enable are both set. A small synchronous write/read port gives access to the sense, enable and flag registers.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the sense register (address 0), the enable register (address 1) and the flag register (address 2) all read zero, and both request outputs are low.
- R2: The sense field of pin 0 is bits [1:0] of address 0 and that of pin 1 is bits [3:2]. The value 00 selects low level, 01 any change, 10 falling edge and 11 rising edge. Bits with no function read zero.
- R3: In an edge mode, a matching transition of the pin sets that pin's flag, which reads back at bit 6 (pin 0) or bit 7 (pin 1) of address 2. A pulse held for two clock periods is enough. A transition the mode does not select leaves the flag clear.
- R4: A request output is high only when that pin's flag (or its level condition) is true, its enable bit is set (bit 6 for pin 0, bit 7 for pin 1 of address 1) and the global enable input is high. Clearing either enable drops the request without touching the flag.
- R5: A one-cycle pulse on a pin's acknowledge input clears that pin's flag, and its request then falls.
- R6: Writing a one to a flag bit at address 2 clears that flag. Writing a zero leaves it unchanged, and a write to one pin's bit leaves the other pin's flag unchanged.
- R7: In low-level mode the flag is held clear. The request stays high while the pin is low and enabled, and falls once the pin is high.
- R8: When a new event and a clear (acknowledge or write-one) land in the same cycle, the flag stays set.
- R9: Read data is registered: it shows the register selected by the address one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 2 | Asynchronous external pin levels |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 2 | Per-pin vector acknowledge pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 2 | Registered per-pin interrupt request |

## Verification
Two paths into the flag can collide in one cycle: a freshly detected edge that sets it, and a clear that comes either from a one written to the flag register or from the acknowledge input. The bench provokes the collision by toggling a pin whose flag is already set, in a mode that selects any change. It then counts the two synchronizer edges and the sampling edge, and places the write strobe or the acknowledge pulse on exactly the clock where the event is seen. The flag is read back afterwards: it must still read one, whereas a clear issued in any other cycle leaves it zero.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int ADDR_SENSE  = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_FLAG   = 2;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o,
  output logic valid_o
);

  localparam int CW = $clog2(STAGES + 1);

  logic [STAGES-1:0] chain_q;
  logic [CW-1:0]     fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      fill_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      if (fill_q != CW'(STAGES)) fill_q <= fill_q + 1'b1;
    end
  end

  assign q_o     = chain_q[STAGES-1];
  assign valid_o = (fill_q == CW'(STAGES));

  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   smp_i,
  input  logic   smp_valid_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  input  logic   en_i,
  input  logic   gie_i,
  output logic   flag_o,
  output logic   irq_o
);

  logic prev_q, primed_q;
  logic flag_q, irq_q;
  logic rise, fall, evt, level_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      if (smp_valid_i) primed_q <= 1'b1;
    end
  end

  assign rise      = primed_q &  smp_i & ~prev_q;
  assign fall      = primed_q & ~smp_i &  prev_q;
  assign level_hit = primed_q & ~smp_i;

  always_comb begin
    case (sense_i)
      SENSE_ANY:  evt = rise | fall;
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (sense_i == SENSE_LOW) begin
      flag_q <= 1'b0;
    end else if (evt) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en_i & gie_i &
                      ((sense_i == SENSE_LOW) ? level_hit : flag_q);
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  p_evt_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (evt && sense_i != SENSE_LOW) |=> flag_q);

  p_clear_drops_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt && sense_i != SENSE_LOW) |=> !flag_q);

  p_level_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_LOW) |=> !flag_q);

  p_level_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (sense_i == SENSE_LOW && en_i && gie_i && primed_q && !smp_i) |=> irq_q);

  p_event_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (evt && clr_i && sense_i != SENSE_LOW) |=> flag_q);

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_PINS-1:0]   flag_i,
  output logic [2*NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0]   en_o,
  output logic [NUM_PINS-1:0]   w1c_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int BIT_LSB = DATA_W - NUM_PINS;
  localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(ADDR_SENSE);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADDR_ENABLE);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(ADDR_FLAG);

  logic [2*NUM_PINS-1:0] sense_q;
  logic [NUM_PINS-1:0]   en_q;
  logic [DATA_W-1:0]     rd_nxt, rd_q;
  logic                  unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      en_q    <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_SENSE)  sense_q <= wdata_i[2*NUM_PINS-1:0];
      if (addr_i == A_ENABLE) en_q    <= wdata_i[BIT_LSB +: NUM_PINS];
    end
  end

  assign w1c_o = (wr_en_i && addr_i == A_FLAG) ? wdata_i[BIT_LSB +: NUM_PINS]
                                               : '0;

  always_comb begin
    rd_nxt = '0;
    case (addr_i)
      A_SENSE:  rd_nxt[2*NUM_PINS-1:0]       = sense_q;
      A_ENABLE: rd_nxt[BIT_LSB +: NUM_PINS]  = en_q;
      A_FLAG:   rd_nxt[BIT_LSB +: NUM_PINS]  = flag_i;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign sense_o = sense_q;
  assign en_o    = en_q;
  assign rdata_o = rd_q;

  p_enable_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == A_ENABLE) |=> (en_q == $past(wdata_i[BIT_LSB +: NUM_PINS])));

  p_no_w1c_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |-> (w1c_o == '0));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                gie_i,
  input  logic [NUM_PINS-1:0] ack_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [2*NUM_PINS-1:0] sense_flat;
  logic [NUM_PINS-1:0]   en;
  logic [NUM_PINS-1:0]   w1c;
  logic [NUM_PINS-1:0]   flag;
  logic [NUM_PINS-1:0]   smp;
  logic [NUM_PINS-1:0]   smp_valid;

  ext_irq_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag),
    .sense_o (sense_flat),
    .en_o    (en),
    .w1c_o   (w1c),
    .rdata_o (rdata_o)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_i     (pin_i[g]),
      .q_o     (smp[g]),
      .valid_o (smp_valid[g])
    );

    ext_irq_detect u_det (
      .clk         (clk),
      .rst         (rst),
      .smp_i       (smp[g]),
      .smp_valid_i (smp_valid[g]),
      .sense_i     (sense_e'(sense_flat[2*g +: 2])),
      .clr_i       (ack_i[g] | w1c[g]),
      .en_i        (en[g]),
      .gie_i       (gie_i),
      .flag_o      (flag[g]),
      .irq_o       (irq_o[g])
    );

    p_irq_gated_r4: assert property (@(posedge clk) disable iff (rst)
      !(en[g] && gie_i) |=> !irq_o[g]);
  end

endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pins;
  logic       gie;
  logic [1:0] ack;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl uut (
    .clk     (clk),
    .rst     (rst),
    .pin_i   (pins),
    .gie_i   (gie),
    .ack_i   (ack),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse_ack(input int p);
    @(negedge clk);
    ack[p] = 1'b1;
    @(negedge clk);
    ack = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; pins = 2'b11; gie = 1'b0; ack = 2'b00;
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    idle(4);
    rst = 1'b0;
    idle(4);

    // R1 reset state
    rd(2'd0, v); chk("R1 sense", v, 8'h00);
    rd(2'd1, v); chk("R1 enable", v, 8'h00);
    rd(2'd2, v); chk("R1 flag", v, 8'h00);
    chk("R1 irq", {6'd0, irq}, 8'h00);

    // R2 / R9 field layout and registered read
    wr(2'd0, 8'hFB);
    rd(2'd0, v); chk("R2 sense readback", v, 8'h0B);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R2 enable readback", v, 8'hC0);
    rd(2'd3, v); chk("R2 unused address", v, 8'h00);
    @(negedge clk); addr = 2'd1;
    @(negedge clk); addr = 2'd0;
    chk("R9 read latency", rdata, 8'hC0);
    @(negedge clk);
    chk("R9 read follows", rdata, 8'h0B);

    gie = 1'b1;
    pins = 2'b11;

    // R2/R3/R4/R5 sweep over pins, edge modes and directions
    for (int p = 0; p < 2; p++) begin
      for (int m = 1; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic expf;
          expf = (m == 1) || (m == 3 && dir == 0) || (m == 2 && dir == 1);
          wr(2'd0, 8'(m << (2 * p)) | 8'(3 << (2 * (1 - p))));
          pins[p] = (dir == 1);
          idle(5);
          wr(2'd2, 8'hC0);
          idle(2);
          pins[p] = (dir == 0);
          idle(6);
          rd(2'd2, v);
          chk("R3 flag after edge", {7'd0, v[6 + p]}, {7'd0, expf});
          chk("R4 irq after edge", {7'd0, irq[p]}, {7'd0, expf});
          if (expf) begin
            pulse_ack(p);
            idle(2);
            rd(2'd2, v);
            chk("R5 flag after ack", {7'd0, v[6 + p]}, 8'h00);
            chk("R5 irq after ack", {7'd0, irq[p]}, 8'h00);
          end
        end
      end
    end

    // R3 two-cycle pulse in rising mode on pin 0
    wr(2'd0, 8'h03);
    pins = 2'b00;
    idle(5);
    wr(2'd2, 8'hC0);
    @(negedge clk); pins[0] = 1'b1;
    idle(2);        pins[0] = 1'b0;
    idle(6);
    rd(2'd2, v); chk("R3 short pulse", v & 8'h40, 8'h40);

    // R4 global and pin enable gating with flags set on both pins
    wr(2'd0, 8'h0F);
    pins = 2'b11;
    idle(6);
    rd(2'd2, v); chk("R4 both flags", v, 8'hC0);
    gie = 1'b0; idle(3);
    chk("R4 gie low", {6'd0, irq}, 8'h00);
    gie = 1'b1; idle(3);
    chk("R4 gie high", {6'd0, irq}, 8'h03);
    wr(2'd1, 8'h40); idle(2);
    chk("R4 pin1 disabled", {6'd0, irq}, 8'h01);
    rd(2'd2, v); chk("R4 flag kept", v, 8'hC0);
    wr(2'd1, 8'hC0);

    // R6 write-one-to-clear
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R6 zero write", v, 8'hC0);
    wr(2'd2, 8'h80);
    rd(2'd2, v); chk("R6 clear pin1 only", v, 8'h40);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk("R6 clear pin0", v, 8'h00);

    // R7 level mode on pin 0, starting with its flag set
    wr(2'd0, 8'h01);
    pins[0] = 1'b0; idle(6);
    rd(2'd2, v); chk("R7 flag set before", v & 8'h40, 8'h40);
    wr(2'd0, 8'h00);
    idle(4);
    rd(2'd2, v); chk("R7 flag held clear", v & 8'h40, 8'h00);
    chk("R7 irq while low", {7'd0, irq[0]}, 8'h01);
    idle(10);
    chk("R7 irq still low", {7'd0, irq[0]}, 8'h01);
    pins[0] = 1'b1; idle(5);
    chk("R7 irq after high", {7'd0, irq[0]}, 8'h00);
    rd(2'd2, v); chk("R7 flag stays clear", v & 8'h40, 8'h00);

    // R8 event and write-one-to-clear in the same cycle on pin 1
    wr(2'd0, 8'h04);
    pins[1] = 1'b0; idle(6);
    rd(2'd2, v); chk("R8 flag preset", v & 8'h80, 8'h80);
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 8'h80;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
    rd(2'd2, v); chk("R8 write collide", v & 8'h80, 8'h80);
    // same collision through acknowledge
    @(negedge clk); pins[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); ack[1] = 1'b1;
    @(negedge clk); ack = 2'b00;
    rd(2'd2, v); chk("R8 ack collide", v & 8'h80, 8'h80);
    // a clear one cycle later does clear
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); ack[1] = 1'b1;
    @(negedge clk); ack = 2'b00;
    rd(2'd2, v); chk("R8 late ack clears", v & 8'h80, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule